// File: doc/BRIEF.md
# Split-Permission Direct-Mapped Translation Cache

This block caches virtual-to-physical page translations for a processor pipeline. It is direct-mapped. For each slot it keeps one physical page base and three independent virtual-page tags: one for instruction fetch, one for data load and one for data store. A lookup presents a virtual page number and an access kind. The block answers in the same cycle with a hit flag and the physical page base, read from the registered arrays.

Neighbouring logic walks the page tables and checks permissions. It then installs a translation through the refill port, passing the page numbers and the effective read, write and execute rights. Each tag is written with the page number only when the matching right is granted; otherwise it is written with the invalid pattern. A later access of a kind that was not granted therefore misses, and the slow path handles it.

A flush clears the whole cache and, one cycle later, pulses an output that asks the instruction cache to invalidate itself as well.

Tags are one bit wider than the page number. The all-ones tag, with its top bit set, can never match a legal page number, including the all-ones page.

Top module: `split_tlb`

## Requirements
- R1: After reset every lookup of every page and kind misses, and `icache_inval_o` is 0.
- R2: The slot is the page number modulo ENTRIES (its low bits). The full page number is compared, so another page that maps to the same slot misses, and page all-ones can be cached and hit.
- R3: Kind encoding is 0 = fetch, 1 = load, 2 = store, 3 = none. A fetch lookup hits only if the last refill of that page granted execute.
- R4: A load lookup (kind 1) hits only if the last refill of that page granted read.
- R5: A store lookup (kind 2) hits only if the last refill of that page granted write.
- R6: On a hit `lk_ppn_o` is the physical page base given at refill; on a miss it is 0.
- R7: A lookup in the same cycle as a refill of the same slot sees the old contents; the new entry is visible from the next cycle.
- R8: A flush leaves every slot invalid for all three kinds from the next cycle.
- R9: When flush and refill are asserted in the same cycle, the flush wins and the refilled page is not cached.
- R10: `icache_inval_o` is 1 exactly in the cycle after each cycle with `flush_i` high, and 0 otherwise.
- R11: A lookup of kind 3 never hits.
- R12: A refill replaces the previous entry of its slot for all kinds, even when it grants no rights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| lk_vpn_i | input | VPN_W | Lookup virtual page number |
| lk_kind_i | input | 2 | Lookup access kind (0 fetch, 1 load, 2 store, 3 none) |
| lk_hit_o | output | 1 | Lookup hit |
| lk_ppn_o | output | PPN_W | Physical page base on hit, else 0 |
| fill_en_i | input | 1 | Refill strobe |
| fill_vpn_i | input | VPN_W | Refill virtual page number |
| fill_ppn_i | input | PPN_W | Refill physical page base |
| fill_rd_i | input | 1 | Effective read permission |
| fill_wr_i | input | 1 | Effective write permission |
| fill_ex_i | input | 1 | Effective execute permission |
| icache_inval_o | output | 1 | Instruction-cache invalidate pulse |

## Verification
The assertions check on every cycle the rules that hold locally:
- a flush is followed by a cycle of all misses and by the invalidate pulse;
- kind 3 never hits;
- a miss reports page 0;
- a refill without a given right makes the next lookup of that page and kind miss.

Other behaviour depends on the history of the arrays, so only the bench scenarios can show it:
- that a granted right does hit with the right physical page;
- aliasing between pages that share a slot;
- same-cycle refill visibility;
- flush winning over refill;
- caching of the all-ones page.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_NONE  = 2'd3
  } acc_kind_e;

  localparam int unsigned NUM_KINDS = 3;
endpackage

// File: rtl/tlb_tag_array.sv
module tlb_tag_array #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned TAG_W   = 9,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o
);
  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [TAG_W-1:0] tag_d [ENTRIES];
  logic             tag_en;

  assign tag_en = flush_i | wr_en_i;

  always_comb begin
    tag_d = tag_q;
    if (flush_i) begin
      for (int i = 0; i < ENTRIES; i++) tag_d[i] = '1;
    end else if (wr_en_i) begin
      tag_d[wr_idx_i] = wr_tag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= '1;
    end else if (tag_en) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= tag_d[i];
    end
  end

  assign rd_tag_o = tag_q[rd_idx_i];
endmodule

// File: rtl/tlb_data_array.sv
module tlb_data_array #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned PPN_W   = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [PPN_W-1:0] wr_ppn_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [PPN_W-1:0] rd_ppn_o
);
  logic [PPN_W-1:0] ppn_q [ENTRIES];
  logic [PPN_W-1:0] ppn_d [ENTRIES];

  always_comb begin
    ppn_d = ppn_q;
    if (wr_en_i) ppn_d[wr_idx_i] = wr_ppn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) ppn_q[i] <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < ENTRIES; i++) ppn_q[i] <= ppn_d[i];
    end
  end

  assign rd_ppn_o = ppn_q[rd_idx_i];
endmodule

// File: rtl/split_tlb.sv
module split_tlb #(
  parameter int unsigned ENTRIES = 4,
  parameter int unsigned VPN_W   = 8,
  parameter int unsigned PPN_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush_i,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [1:0]       lk_kind_i,
  output logic             lk_hit_o,
  output logic [PPN_W-1:0] lk_ppn_o,
  input  logic             fill_en_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             fill_ex_i,
  output logic             icache_inval_o
);
  import tlb_pkg::*;

  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = VPN_W + 1;

  logic [IDX_W-1:0]     lk_idx;
  logic [IDX_W-1:0]     fill_idx;
  logic [NUM_KINDS-1:0] kind_perm;
  logic [TAG_W-1:0]     kind_tag [NUM_KINDS];
  logic [TAG_W-1:0]     lk_tag;
  logic [TAG_W-1:0]     sel_tag;
  logic [PPN_W-1:0]     slot_ppn;
  logic                 fill_go;
  logic                 inval_d, inval_q;
  acc_kind_e            lk_kind;

  assign lk_idx   = lk_vpn_i[IDX_W-1:0];
  assign fill_idx = fill_vpn_i[IDX_W-1:0];
  assign fill_go  = fill_en_i & ~flush_i;
  assign lk_tag   = {1'b0, lk_vpn_i};
  assign lk_kind  = acc_kind_e'(lk_kind_i);

  // Right that each tag array follows, indexed by kind encoding
  assign kind_perm[ACC_FETCH] = fill_ex_i;
  assign kind_perm[ACC_LOAD]  = fill_rd_i;
  assign kind_perm[ACC_STORE] = fill_wr_i;

  for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
    logic [TAG_W-1:0] wr_tag;
    assign wr_tag = kind_perm[k] ? {1'b0, fill_vpn_i} : {TAG_W{1'b1}};

    tlb_tag_array #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush_i  (flush_i),
      .wr_en_i  (fill_go),
      .wr_idx_i (fill_idx),
      .wr_tag_i (wr_tag),
      .rd_idx_i (lk_idx),
      .rd_tag_o (kind_tag[k])
    );
  end

  tlb_data_array #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) u_data (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (fill_go),
    .wr_idx_i (fill_idx),
    .wr_ppn_i (fill_ppn_i),
    .rd_idx_i (lk_idx),
    .rd_ppn_o (slot_ppn)
  );

  always_comb begin
    case (lk_kind)
      ACC_FETCH: sel_tag = kind_tag[ACC_FETCH];
      ACC_LOAD:  sel_tag = kind_tag[ACC_LOAD];
      ACC_STORE: sel_tag = kind_tag[ACC_STORE];
      default:   sel_tag = {TAG_W{1'b1}};
    endcase
  end

  assign lk_hit_o = (sel_tag == lk_tag);
  assign lk_ppn_o = lk_hit_o ? slot_ppn : '0;

  assign inval_d = flush_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) inval_q <= 1'b0;
    else        inval_q <= inval_d;
  end

  assign icache_inval_o = inval_q;
endmodule

// File: rtl/tlb_checker.sv
module tlb_checker #(
  parameter int unsigned VPN_W = 8,
  parameter int unsigned PPN_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush_i,
  input logic [VPN_W-1:0] lk_vpn_i,
  input logic [1:0]       lk_kind_i,
  input logic             lk_hit_o,
  input logic [PPN_W-1:0] lk_ppn_o,
  input logic             fill_en_i,
  input logic [VPN_W-1:0] fill_vpn_i,
  input logic             fill_rd_i,
  input logic             fill_wr_i,
  input logic             fill_ex_i,
  input logic             icache_inval_o
);
  assert_inval_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> icache_inval_o);
  assert_inval_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !flush_i |=> !icache_inval_o);
  assert_miss_after_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !lk_hit_o);
  assert_no_kind3_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_kind_i == 2'd3) |-> !lk_hit_o);
  assert_miss_ppn_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit_o |-> (lk_ppn_o == '0));
  assert_no_ex_no_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !fill_ex_i) |=>
      !(lk_hit_o && lk_kind_i == 2'd0 && lk_vpn_i == $past(fill_vpn_i)));
  assert_no_rd_no_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !fill_rd_i) |=>
      !(lk_hit_o && lk_kind_i == 2'd1 && lk_vpn_i == $past(fill_vpn_i)));
  assert_no_wr_no_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en_i && !fill_wr_i) |=>
      !(lk_hit_o && lk_kind_i == 2'd2 && lk_vpn_i == $past(fill_vpn_i)));
endmodule

bind split_tlb tlb_checker #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .flush_i        (flush_i),
  .lk_vpn_i       (lk_vpn_i),
  .lk_kind_i      (lk_kind_i),
  .lk_hit_o       (lk_hit_o),
  .lk_ppn_o       (lk_ppn_o),
  .fill_en_i      (fill_en_i),
  .fill_vpn_i     (fill_vpn_i),
  .fill_rd_i      (fill_rd_i),
  .fill_wr_i      (fill_wr_i),
  .fill_ex_i      (fill_ex_i),
  .icache_inval_o (icache_inval_o)
);

// File: tb/tb_split_tlb.sv
module tb_split_tlb;
  localparam int ENTRIES = 4;
  localparam int VPN_W   = 8;
  localparam int PPN_W   = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             flush_i = 1'b0;
  logic [VPN_W-1:0] lk_vpn_i = '0;
  logic [1:0]       lk_kind_i = '0;
  logic             lk_hit_o;
  logic [PPN_W-1:0] lk_ppn_o;
  logic             fill_en_i = 1'b0;
  logic [VPN_W-1:0] fill_vpn_i = '0;
  logic [PPN_W-1:0] fill_ppn_i = '0;
  logic             fill_rd_i = 1'b0, fill_wr_i = 1'b0, fill_ex_i = 1'b0;
  logic             icache_inval_o;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  split_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Lookup in the current cycle, outputs are combinational from registers
  task automatic look(input string req, input int vpn, input int kind,
                      input bit exp_hit, input int exp_ppn);
    lk_vpn_i  = vpn[VPN_W-1:0];
    lk_kind_i = kind[1:0];
    #1;
    chk({req, " hit"}, {31'd0, lk_hit_o}, {31'd0, exp_hit});
    chk({req, " ppn"}, {24'd0, lk_ppn_o}, exp_hit ? exp_ppn : 0);
  endtask

  task automatic fill(input int vpn, input int ppn, input bit rd, input bit wr, input bit ex);
    @(negedge clk);
    fill_en_i = 1'b1; fill_vpn_i = vpn[VPN_W-1:0]; fill_ppn_i = ppn[PPN_W-1:0];
    fill_rd_i = rd; fill_wr_i = wr; fill_ex_i = ex;
    @(negedge clk);
    fill_en_i = 1'b0;
  endtask

  task automatic all_miss(input string req, input int vpn);
    for (int k = 0; k < 4; k++) look(req, vpn, k, 1'b0, 0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state, sweep pages and kinds
    chk("R1 inval", {31'd0, icache_inval_o}, 0);
    for (int v = 0; v < 256; v += 17) all_miss("R1", v);
    all_miss("R1", 255);

    // R3 R4 R5 R6 R11 R12 R2: permission combinations p = {ex,wr,rd}
    for (int p = 0; p < 8; p++) begin
      int ppn;
      ppn = 8'hA0 + p;
      fill(p, ppn, p[0], p[1], p[2]);
      look("R3 fetch", p, 0, p[2], ppn);
      look("R4 load",  p, 1, p[0], ppn);
      look("R5 store", p, 2, p[1], ppn);
      look("R11 none", p, 3, 1'b0, 0);
      all_miss("R2 alias", p + ENTRIES);
      all_miss("R2 high alias", p + 128);
      if (p >= ENTRIES) all_miss("R12 replaced", p - ENTRIES);
    end

    // R7: same-cycle refill at slot 1 (holds page 5) with page 9
    @(negedge clk);
    fill_en_i = 1'b1; fill_vpn_i = 8'd9; fill_ppn_i = 8'h55;
    fill_rd_i = 1'b1; fill_wr_i = 1'b1; fill_ex_i = 1'b1;
    look("R7 old miss", 9, 1, 1'b0, 0);
    look("R7 old hit", 5, 1, 1'b1, 8'hA5);
    @(negedge clk);
    fill_en_i = 1'b0;
    look("R7 new hit", 9, 1, 1'b1, 8'h55);
    all_miss("R7 old gone", 5);

    // R8 R10: flush after full slots
    for (int v = 0; v < ENTRIES; v++) fill(v, 8'h10 + v, 1'b1, 1'b1, 1'b1);
    for (int v = 0; v < ENTRIES; v++) look("R8 pre", v, 2, 1'b1, 8'h10 + v);
    @(negedge clk);
    flush_i = 1'b1;
    #1 chk("R10 not yet", {31'd0, icache_inval_o}, 0);
    @(negedge clk);
    flush_i = 1'b0;
    #1 chk("R10 pulse", {31'd0, icache_inval_o}, 1);
    for (int v = 0; v < ENTRIES; v++) all_miss("R8 flushed", v);
    @(negedge clk);
    #1 chk("R10 end", {31'd0, icache_inval_o}, 0);

    // R9: flush beats refill
    fill(2, 8'h22, 1'b1, 1'b1, 1'b1);
    look("R9 pre", 2, 0, 1'b1, 8'h22);
    @(negedge clk);
    flush_i = 1'b1;
    fill_en_i = 1'b1; fill_vpn_i = 8'd3; fill_ppn_i = 8'h33;
    fill_rd_i = 1'b1; fill_wr_i = 1'b1; fill_ex_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0; fill_en_i = 1'b0;
    all_miss("R9 refill dropped", 3);
    all_miss("R9 flushed", 2);

    // R2: the all-ones page is cacheable
    all_miss("R2 ff before", 255);
    fill(255, 8'hEE, 1'b1, 1'b0, 1'b1);
    look("R2 ff load", 255, 1, 1'b1, 8'hEE);
    look("R2 ff fetch", 255, 0, 1'b1, 8'hEE);
    look("R5 ff store", 255, 2, 1'b0, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule